// File: doc/BRIEF.md
# Triggered ADC Sequence Controller

This block paces a sampling converter front end. Software programs a set of shadow registers: how many samples form one sequence, how many sequences a single run holds, how long to wait after a trigger, and which of eight input channels to convert. Writing the control register with its run bit set copies the shadow values into the working set, clears the status counters and arms the controller. Later writes to the shadow registers are held and have no effect until the run bit is written again. Writing the control register with the run bit clear stops the controller from any state.

Once armed, the controller waits for a trigger. The trigger can be a software kick register, a rising edge on the pulse input, or a falling edge on it. The pulse input passes through a two-stage synchronizer and an edge detector, so a long pulse counts as one trigger. After a trigger it waits the programmed delay plus a fixed pipeline latency. It then requests conversions one at a time and counts each returned sample. A finished sequence either leads straight into the next one, in single mode, or re-arms for a fresh trigger, in loop mode. Single mode stops once the programmed number of sequences is complete and raises a done flag.

The conversion request is a valid/ready pair. `conv_req` stays high with a stable `conv_ch` until the converter accepts it with `conv_rdy`. Only one request is outstanding at a time, and no new request is made until `sample_vld` returns the sample. The converter can stall for as long as it likes by holding `conv_rdy` low.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `st_state` is 0 (idle), `conv_req` is 0, both counters read 0 and `st_done` is 0.
- R2: Writes to address 1 (samples per sequence, bits 15:0), address 2 (sequences per run, bits 15:0) and address 3 (delay in bits 15:0, channel in bits 18:16) go to shadow storage only. A running sequence keeps the values latched at its run command.
- R3: A write to address 0 with bit 0 set latches the shadow values, takes loop mode from bit 1 and the trigger source from bits 3:2, clears both counters and `st_done`, and enters state 1 (waiting for trigger) on the next cycle. A write to address 0 with bit 0 clear enters state 0 on the next cycle from any state, with `conv_req` low.
- R4: The trigger source is encoded as 0 = a write to address 4, 1 = rising edge of `trig_in`, 2 = falling edge of `trig_in`, 3 = rising edge. Triggers of a source that is not selected, and any trigger outside state 1, are ignored.
- R5: A pulse held active for many cycles starts exactly one sequence.
- R6: `conv_req` first rises delay + 4 clock cycles after the edge that first samples the trigger at its active level, or after the edge that takes the kick write. During the delay, `st_state` is 2.
- R7: While requesting, the controller is in state 3. `conv_req` holds and `conv_ch` stays stable until `conv_rdy` accepts the request. A `sample_vld` that arrives with no request outstanding is not counted.
- R8: When the programmed number of samples has been counted, `st_state` is 4 for exactly one cycle and `st_seqs` increases by one. A programmed value of 0 samples or 0 sequences is treated as 1.
- R9: In single mode (bit 1 = 0), sequences run back to back without a new trigger. After the last one, `st_state` is 5 and `st_done` stays 1 until the next run command.
- R10: In loop mode (bit 1 = 1), every finished sequence returns to state 1, the sequence count is not a limit, and state 5 is never reached.
- R11: `st_samples` counts samples in the current sequence and is cleared when a sequence starts. `st_seqs` counts sequences finished since the run command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| trig_in | input | 1 | Hardware trigger pulse, asynchronous |
| conv_req | output | 1 | Conversion request (valid) |
| conv_rdy | input | 1 | Converter accepts request (ready) |
| conv_ch | output | 3 | Channel to convert |
| sample_vld | input | 1 | Converter returns one sample |
| st_state | output | 3 | Current state code |
| st_samples | output | 16 | Samples counted in current sequence |
| st_seqs | output | 16 | Sequences finished since run |
| st_done | output | 1 | Single-mode run complete |

## Verification
The hardest situation to reach is a stalled converter combined with stray `sample_vld` pulses in the middle of a multi-sequence run. That is the only case in which an uncounted sample or a dropped request would change the counters. A converter model in the bench drives `conv_rdy` from a pseudo-random pattern, answers accepted requests after a variable latency and injects stray sample pulses while no request is outstanding. A cycle-level reference model tracks every output. Shadow writes made while a loop run is active, and a second pulse sent during the delay window, reach the other cases that depend on ordering.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_DELAY  = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_SEQEND = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_SOFT     = 2'd0,
    SRC_RISE     = 2'd1,
    SRC_FALL     = 2'd2,
    SRC_RISE_ALT = 2'd3
  } trig_src_e;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_NSAMP  = 3'd1;
  localparam logic [2:0] ADDR_NSEQ   = 3'd2;
  localparam logic [2:0] ADDR_TIMING = 3'd3;
  localparam logic [2:0] ADDR_KICK   = 3'd4;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_LOOP_BIT = 1;
  localparam int CTRL_SRC_LSB  = 2;
  localparam int TIMING_CH_LSB = 16;

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int DLY_W  = 16,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              run_set,
  output logic              run_clr,
  output logic              kick,
  output logic              act_loop,
  output trig_src_e         act_src,
  output logic [CNT_W-1:0]  act_nsamp,
  output logic [CNT_W-1:0]  act_nseq,
  output logic [DLY_W-1:0]  act_dly,
  output logic [CH_W-1:0]   act_ch
);

  logic [CNT_W-1:0] shd_nsamp, shd_nseq;
  logic [DLY_W-1:0] shd_dly;
  logic [CH_W-1:0]  shd_ch;
  logic             wr_ctrl;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  assign wr_ctrl = cfg_wr && (cfg_addr == ADDR_CTRL);
  assign run_set = wr_ctrl && cfg_wdata[CTRL_RUN_BIT];
  assign run_clr = wr_ctrl && !cfg_wdata[CTRL_RUN_BIT];
  assign kick    = cfg_wr && (cfg_addr == ADDR_KICK);

  // shadow copies, written freely at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_nsamp <= CNT_W'(1);
      shd_nseq  <= CNT_W'(1);
      shd_dly   <= '0;
      shd_ch    <= '0;
    end else if (cfg_wr) begin
      unique case (cfg_addr)
        ADDR_NSAMP:  shd_nsamp <= cfg_wdata[CNT_W-1:0];
        ADDR_NSEQ:   shd_nseq  <= cfg_wdata[CNT_W-1:0];
        ADDR_TIMING: begin
          shd_dly <= cfg_wdata[DLY_W-1:0];
          shd_ch  <= cfg_wdata[TIMING_CH_LSB +: CH_W];
        end
        default: ;
      endcase
    end
  end

  // working set, loaded only by a run command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_loop  <= 1'b0;
      act_src   <= SRC_RISE;
      act_nsamp <= CNT_W'(1);
      act_nseq  <= CNT_W'(1);
      act_dly   <= '0;
      act_ch    <= '0;
    end else if (run_set) begin
      act_loop  <= cfg_wdata[CTRL_LOOP_BIT];
      act_src   <= trig_src_e'(cfg_wdata[CTRL_SRC_LSB +: 2]);
      act_nsamp <= at_least_one(shd_nsamp);
      act_nseq  <= at_least_one(shd_nseq);
      act_dly   <= shd_dly;
      act_ch    <= shd_ch;
    end
  end

endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      trig_in,
  input  logic      kick,
  input  trig_src_e src,
  output logic      trig_evt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] kick_q;
  logic                   last_q;
  logic                   rise, fall;

  // synchronizer for the pulse input and a matching delay line for the
  // software kick so both sources see the same latency
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q[0] <= 1'b0;
          kick_q[0] <= 1'b0;
        end else begin
          sync_q[0] <= trig_in;
          kick_q[0] <= kick;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q[i] <= 1'b0;
          kick_q[i] <= 1'b0;
        end else begin
          sync_q[i] <= sync_q[i-1];
          kick_q[i] <= kick_q[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] && !last_q;
  assign fall = !sync_q[SYNC_STAGES-1] && last_q;

  always_comb begin
    unique case (src)
      SRC_SOFT: trig_evt = kick_q[SYNC_STAGES-1];
      SRC_FALL: trig_evt = fall;
      default:  trig_evt = rise;
    endcase
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DLY_W    = 16,
  parameter int CH_W     = 3,
  parameter int LOAD_ADJ = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_set,
  input  logic             run_clr,
  input  logic             trig_evt,
  input  logic             act_loop,
  input  logic [CNT_W-1:0] act_nsamp,
  input  logic [CNT_W-1:0] act_nseq,
  input  logic [DLY_W-1:0] act_dly,
  input  logic [CH_W-1:0]  act_ch,
  output logic             conv_req,
  input  logic             conv_rdy,
  output logic [CH_W-1:0]  conv_ch,
  input  logic             sample_vld,
  output logic [2:0]       st_state,
  output logic [CNT_W-1:0] st_samples,
  output logic [CNT_W-1:0] st_seqs,
  output logic             st_done
);

  localparam int CD_W = DLY_W + 1;

  seq_state_e       state_q;
  logic [CD_W-1:0]  wait_q;
  logic [CD_W-1:0]  wait_load;
  logic [CNT_W-1:0] samp_q, seq_q, seq_inc;
  logic             pend_q, done_q, samp_last;

  assign wait_load = {1'b0, act_dly} + CD_W'(LOAD_ADJ);
  assign seq_inc   = seq_q + CNT_W'(1);
  assign samp_last = (samp_q + CNT_W'(1)) == act_nsamp;

  assign conv_req   = (state_q == ST_SAMPLE) && !pend_q;
  assign conv_ch    = act_ch;
  assign st_state   = state_q;
  assign st_samples = samp_q;
  assign st_seqs    = seq_q;
  assign st_done    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      samp_q  <= '0;
      seq_q   <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (run_set) begin
      state_q <= ST_WAIT;
      samp_q  <= '0;
      seq_q   <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (run_clr) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (trig_evt) begin
            state_q <= ST_DELAY;
            wait_q  <= wait_load;
          end
        end
        ST_DELAY: begin
          if (wait_q == '0) begin
            state_q <= ST_SAMPLE;
            samp_q  <= '0;
            pend_q  <= 1'b0;
          end else begin
            wait_q <= wait_q - CD_W'(1);
          end
        end
        ST_SAMPLE: begin
          if (conv_req && conv_rdy) begin
            pend_q <= 1'b1;
          end else if (pend_q && sample_vld) begin
            samp_q <= samp_q + CNT_W'(1);
            pend_q <= 1'b0;
            if (samp_last) state_q <= ST_SEQEND;
          end
        end
        ST_SEQEND: begin
          seq_q <= seq_inc;
          if (act_loop) begin
            state_q <= ST_WAIT;
          end else if (seq_inc == act_nseq) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_SAMPLE;
            samp_q  <= '0;
            pend_q  <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int DLY_W       = 16,
  parameter int CH_W        = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FIXED_LAT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              trig_in,
  output logic              conv_req,
  input  logic              conv_rdy,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              sample_vld,
  output logic [2:0]        st_state,
  output logic [CNT_W-1:0]  st_samples,
  output logic [CNT_W-1:0]  st_seqs,
  output logic              st_done
);

  // cycles spent in synchronizer and edge register are taken out of the
  // fixed latency; the remainder is added to the programmed delay
  localparam int LOAD_ADJ = FIXED_LAT - SYNC_STAGES - 1;

  logic             run_set, run_clr, kick, trig_evt;
  logic             act_loop;
  trig_src_e        act_src;
  logic [CNT_W-1:0] act_nsamp, act_nseq;
  logic [DLY_W-1:0] act_dly;
  logic [CH_W-1:0]  act_ch;

  adc_seq_cfg #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .DLY_W(DLY_W), .CH_W(CH_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .run_set(run_set), .run_clr(run_clr), .kick(kick),
    .act_loop(act_loop), .act_src(act_src),
    .act_nsamp(act_nsamp), .act_nseq(act_nseq),
    .act_dly(act_dly), .act_ch(act_ch)
  );

  adc_seq_trig #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_trig (
    .clk(clk), .rst_n(rst_n),
    .trig_in(trig_in), .kick(kick), .src(act_src),
    .trig_evt(trig_evt)
  );

  adc_seq_fsm #(
    .CNT_W(CNT_W), .DLY_W(DLY_W), .CH_W(CH_W), .LOAD_ADJ(LOAD_ADJ)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .run_set(run_set), .run_clr(run_clr), .trig_evt(trig_evt),
    .act_loop(act_loop), .act_nsamp(act_nsamp), .act_nseq(act_nseq),
    .act_dly(act_dly), .act_ch(act_ch),
    .conv_req(conv_req), .conv_rdy(conv_rdy), .conv_ch(conv_ch),
    .sample_vld(sample_vld),
    .st_state(st_state), .st_samples(st_samples),
    .st_seqs(st_seqs), .st_done(st_done)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CNT_W = 16,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [2:0]       cfg_addr,
  input logic             cfg_run_bit,
  input logic             conv_req,
  input logic             conv_rdy,
  input logic [CH_W-1:0]  conv_ch,
  input logic [2:0]       st_state,
  input logic [CNT_W-1:0] st_samples,
  input logic [CNT_W-1:0] st_seqs,
  input logic             st_done,
  input logic             act_loop,
  input logic [CNT_W-1:0] act_nsamp
);

  logic ctrl_wr;
  assign ctrl_wr = cfg_wr && (cfg_addr == 3'd0);

  assert_run_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && cfg_run_bit) |=> (st_state == 3'd1 && !st_done && st_seqs == '0));

  assert_run_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !cfg_run_bit) |=> (st_state == 3'd0 && !conv_req));

  assert_wait_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_state == 3'd1 && !cfg_wr) |=> (st_state == 3'd1 || st_state == 3'd2));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_rdy && !cfg_wr) |=> (conv_req && $stable(conv_ch)));

  assert_samples_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_samples <= act_nsamp);

  assert_seqend_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_state == 3'd4) |=> (st_state != 3'd4));

  assert_done_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> (st_state == 3'd5));

  assert_loop_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_loop && st_state == 3'd4 && !cfg_wr) |=> (st_state == 3'd1));

endmodule

bind adc_seq_ctrl adc_seq_chk #(.CNT_W(CNT_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_run_bit(cfg_wdata[0]),
  .conv_req(conv_req), .conv_rdy(conv_rdy), .conv_ch(conv_ch),
  .st_state(st_state), .st_samples(st_samples), .st_seqs(st_seqs),
  .st_done(st_done), .act_loop(act_loop), .act_nsamp(act_nsamp)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        trig_in = 1'b0;
  logic        conv_req;
  logic        conv_rdy = 1'b0;
  logic [2:0]  conv_ch;
  logic        sample_vld = 1'b0;
  logic [2:0]  st_state;
  logic [15:0] st_samples, st_seqs;
  logic        st_done;

  int    nchk = 0;
  int    nfail = 0;
  string cur_tag = "R1";
  bit    cmp_en = 1'b0;
  bit    rdy_always = 1'b1;
  bit    spur_en = 1'b0;
  int    rsp_cd = 0;
  int    lfsr = 32'h1ace;

  always #2.5 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .trig_in(trig_in),
    .conv_req(conv_req), .conv_rdy(conv_rdy), .conv_ch(conv_ch),
    .sample_vld(sample_vld),
    .st_state(st_state), .st_samples(st_samples),
    .st_seqs(st_seqs), .st_done(st_done)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st, m_dc, m_sc, m_qc;
  bit m_pend, m_done;
  int a_ns, a_nq, a_dly, a_ch, a_src;
  bit a_loop;
  int s_ns, s_nq, s_dly, s_ch;
  bit q1, q2, q3, kq1, kq2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_dc = 0; m_sc = 0; m_qc = 0; m_pend = 0; m_done = 0;
      a_ns = 1; a_nq = 1; a_dly = 0; a_ch = 0; a_src = 1; a_loop = 0;
      s_ns = 1; s_nq = 1; s_dly = 0; s_ch = 0;
      q1 = 0; q2 = 0; q3 = 0; kq1 = 0; kq2 = 0;
    end else begin
      bit evt;
      if (a_src == 0)      evt = kq2;
      else if (a_src == 2) evt = !q2 && q3;
      else                 evt = q2 && !q3;
      if (cfg_wr && cfg_addr == 3'd0) begin
        if (cfg_wdata[0]) begin
          a_ns = (s_ns == 0) ? 1 : s_ns;
          a_nq = (s_nq == 0) ? 1 : s_nq;
          a_dly = s_dly; a_ch = s_ch;
          a_loop = cfg_wdata[1]; a_src = int'(cfg_wdata[3:2]);
          m_st = 1; m_sc = 0; m_qc = 0; m_done = 0; m_pend = 0;
        end else begin
          m_st = 0; m_pend = 0;
        end
      end else begin
        case (m_st)
          1: if (evt) begin m_st = 2; m_dc = a_dly + 1; end
          2: if (m_dc == 0) begin m_st = 3; m_sc = 0; m_pend = 0; end
             else m_dc--;
          3: if (!m_pend && conv_rdy) m_pend = 1;
             else if (m_pend && sample_vld) begin
               m_sc++; m_pend = 0;
               if (m_sc == a_ns) m_st = 4;
             end
          4: begin
            m_qc = (m_qc + 1) & 16'hffff;
            if (a_loop) m_st = 1;
            else if (m_qc == a_nq) begin m_st = 5; m_done = 1; end
            else begin m_st = 3; m_sc = 0; m_pend = 0; end
          end
          default: ;
        endcase
      end
      if (cfg_wr) begin
        if (cfg_addr == 3'd1) s_ns = int'(cfg_wdata[15:0]);
        if (cfg_addr == 3'd2) s_nq = int'(cfg_wdata[15:0]);
        if (cfg_addr == 3'd3) begin s_dly = int'(cfg_wdata[15:0]); s_ch = int'(cfg_wdata[18:16]); end
      end
      q3 = q2; q2 = q1; q1 = trig_in;
      kq2 = kq1; kq1 = cfg_wr && (cfg_addr == 3'd4);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(cur_tag, "model state", int'(st_state), m_st);
      chk(cur_tag, "model conv_req", int'(conv_req), int'(m_st == 3 && !m_pend));
      chk(cur_tag, "model samples", int'(st_samples), m_sc);
      chk(cur_tag, "model seqs", int'(st_seqs), m_qc);
      chk(cur_tag, "model done", int'(st_done), int'(m_done));
      if (m_st == 3) chk(cur_tag, "model conv_ch", int'(conv_ch), a_ch);
    end
  end

  // converter model: ready pattern, return latency, stray samples
  always @(negedge clk) begin
    sample_vld = 1'b0;
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'h80200003 : 32'h0);
    if (rsp_cd > 0) begin
      rsp_cd--;
      if (rsp_cd == 0) sample_vld = 1'b1;
    end else if (spur_en && lfsr[0]) begin
      sample_vld = 1'b1;
    end
    if (conv_req && rsp_cd == 0 && (rdy_always || lfsr[1])) begin
      conv_rdy = 1'b1;
      rsp_cd = 1 + int'(lfsr[3:2]);
    end else begin
      conv_rdy = 1'b0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse(input int len);
    @(negedge clk);
    trig_in = ~trig_in;
    repeat (len) @(negedge clk);
    trig_in = ~trig_in;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_st(input int s, input int lim, input string tag);
    int n = 0;
    while (int'(st_state) != s && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk(tag, "state reached", int'(st_state), s);
  endtask

  // counts negedges until conv_req shows; trigger already applied
  task automatic latency(input int exp_edges, input int drop_at, input string tag);
    int n = 0;
    while (!conv_req && n < 400) begin
      @(negedge clk);
      n++;
      if (n == drop_at) trig_in = ~trig_in;
      if (n == 1) cfg_wr = 1'b0;
    end
    chk(tag, "trigger to request edges", n, exp_edges);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "state", int'(st_state), 0);
    chk("R1", "conv_req", int'(conv_req), 0);
    chk("R1", "samples", int'(st_samples), 0);
    chk("R1", "seqs", int'(st_seqs), 0);
    chk("R1", "done", int'(st_done), 0);
    cmp_en = 1'b1;

    // single mode, rising edge, delay 2, channel 5
    cur_tag = "R9";
    wr(3'd1, 32'd3);
    wr(3'd2, 32'd2);
    wr(3'd3, (32'd5 << 16) | 32'd2);
    wr(3'd0, 32'h5);
    chk("R3", "armed state", int'(st_state), 1);
    @(negedge clk);
    trig_in = 1'b1;
    latency(2 + 5, 3, "R6");
    chk("R7", "channel", int'(conv_ch), 5);
    wait_st(5, 200, "R9");
    chk("R9", "done flag", int'(st_done), 1);
    chk("R11", "sequences finished", int'(st_seqs), 2);
    chk("R8", "samples in last sequence", int'(st_samples), 3);
    idle(6);
    chk("R9", "done holds", int'(st_done), 1);
    chk("R9", "stays done", int'(st_state), 5);

    // loop mode, one long pulse
    cur_tag = "R5";
    wr(3'd1, 32'd2);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'h7);
    chk("R3", "done cleared by run", int'(st_done), 0);
    pulse(14);
    idle(20);
    chk("R5", "one sequence per long pulse", int'(st_seqs), 1);
    chk("R10", "re-armed", int'(st_state), 1);
    pulse(2);
    idle(20);
    chk("R10", "second sequence", int'(st_seqs), 2);
    chk("R10", "never done", int'(st_done), 0);

    // shadow writes while running
    cur_tag = "R2";
    wr(3'd1, 32'd4);
    wr(3'd3, 32'd2 << 16);
    pulse(2);
    idle(25);
    chk("R2", "running set unchanged", int'(st_samples), 2);
    chk("R2", "loop sequences", int'(st_seqs), 3);
    wr(3'd0, 32'h5);
    pulse(2);
    wait_st(5, 300, "R2");
    chk("R2", "new sample count applied", int'(st_samples), 4);
    chk("R11", "new sequence count", int'(st_seqs), 2);

    // software kick, pulse input ignored
    cur_tag = "R4";
    wr(3'd3, 32'd3 << 16);
    wr(3'd1, 32'd1);
    wr(3'd2, 32'd1);
    wr(3'd0, 32'h1);
    pulse(3);
    idle(10);
    chk("R4", "pulse ignored in software mode", int'(st_state), 1);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 3'd4; cfg_wdata = 32'd0;
    latency(0 + 5, -1, "R6");
    chk("R7", "kick channel", int'(conv_ch), 3);
    wait_st(5, 100, "R4");

    // falling edge source
    wr(3'd0, 32'h9);
    @(negedge clk);
    trig_in = 1'b1;
    idle(10);
    chk("R4", "rising edge ignored in falling mode", int'(st_state), 1);
    trig_in = 1'b0;
    latency(0 + 5, -1, "R6");
    wait_st(5, 100, "R4");

    // stop during delay
    cur_tag = "R3";
    wr(3'd3, 32'd200);
    wr(3'd0, 32'h5);
    pulse(2);
    idle(8);
    chk("R6", "in delay", int'(st_state), 2);
    wr(3'd0, 32'h0);
    chk("R3", "stopped", int'(st_state), 0);
    chk("R3", "no request", int'(conv_req), 0);
    idle(250);
    chk("R3", "stays stopped", int'(st_state), 0);

    // retrigger during delay ignored
    cur_tag = "R4";
    wr(3'd3, 32'd20);
    wr(3'd0, 32'h7);
    pulse(2);
    idle(5);
    pulse(2);
    idle(60);
    chk("R4", "retrigger ignored", int'(st_seqs), 1);
    chk("R4", "waiting again", int'(st_state), 1);

    // zero counts treated as one
    cur_tag = "R8";
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'h5);
    pulse(2);
    wait_st(5, 100, "R8");
    chk("R8", "zero samples as one", int'(st_samples), 1);
    chk("R8", "zero sequences as one", int'(st_seqs), 1);

    // back-pressure and stray samples
    cur_tag = "R7";
    rdy_always = 1'b0;
    spur_en = 1'b1;
    wr(3'd1, 32'd6);
    wr(3'd2, 32'd3);
    wr(3'd3, (32'd7 << 16) | 32'd1);
    wr(3'd0, 32'h5);
    pulse(2);
    wait_st(5, 3000, "R7");
    chk("R7", "stray samples not counted", int'(st_samples), 6);
    chk("R7", "sequences under stall", int'(st_seqs), 3);
    spur_en = 1'b0;
    idle(10);
    chk("R7", "done holds after strays", int'(st_samples), 6);

    cmp_en = 1'b0;
    summary();
    $finish;
  end

endmodule